// File: doc/BRIEF.md
# Bitstream Container Header Parser

The block takes a configuration-file container one byte at a time and hands on only the raw bitstream inside it. It first checks a fixed 13-byte opening signature. It then walks a chain of tagged sections. Each section is a one-byte ASCII tag, then a big-endian length, then that many bytes of content. Sections tagged `a` through `d` are consumed and dropped. When the parser reaches the `e` section, it reports that section's length and streams the section's content out unchanged. It marks the final byte and then goes idle in a done state.

The input and output both use valid/ready handshakes. During the payload the parser sits directly in the data path: an input byte is accepted only when the output side takes it. Any malformed or cut-short container gives a sticky error with a code that says why. After an error, or once the payload has been delivered, every further input byte is consumed and produces no output.

Top module: `bitstream_container_parser`

## Requirements
- R1: After reset, in_ready_o is 1 and out_valid_o, len_valid_o, err_o and done_o are all 0.
- R2: The first 13 bytes must equal 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01. A byte that differs at any of these positions sets err_o with err_code_o = 1.
- R3: A section whose tag byte is 0x61..0x64 carries a 2-byte big-endian length, including zero. Its content bytes are consumed without any output.
- R4: A tag byte outside 0x61..0x65 sets err_code_o = 2. If that byte also carries in_last_i, code 2 still takes precedence over code 4.
- R5: A short (non-0x65) section length above 255 sets err_code_o = 3. A length of exactly 255 is accepted, and the 0x65 section is not limited to 255.
- R6: Tag 0x65 carries a 4-byte big-endian length. That length appears on len_o with len_valid_o = 1 as soon as its last length byte is accepted, before any payload byte. Both then hold until reset.
- R7: Payload bytes leave on out_data_o unchanged and in order. During the payload, out_valid_o follows in_valid_o and in_ready_o follows out_ready_i.
- R8: The final payload byte has out_last_o = 1 and no earlier byte does. done_o is 1 from the next cycle, and later input is consumed without output. A zero payload length goes straight to done with no output.
- R9: If in_last_i comes with any byte before the payload is complete, err_code_o = 4. In_last_i on the final payload byte, or on the final length byte of a zero-length payload, is not an error.
- R10: err_o and err_code_o hold until reset. While err_o is 1, in_ready_o is 1 and out_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | Container byte |
| in_valid_i | input | 1 | Input byte valid |
| in_last_i | input | 1 | Input byte is the final byte of the container |
| in_ready_o | output | 1 | Input byte accepted when high with in_valid_i |
| out_data_o | output | 8 | Payload byte |
| out_valid_o | output | 1 | Payload byte valid |
| out_last_o | output | 1 | Payload byte is the final one |
| out_ready_i | input | 1 | Downstream takes the payload byte |
| len_o | output | 32 | Payload length in bytes |
| len_valid_o | output | 1 | len_o holds the payload length |
| done_o | output | 1 | Payload fully delivered |
| err_o | output | 1 | Container rejected |
| err_code_o | output | 3 | 0 none, 1 signature, 2 bad tag, 3 short section too long, 4 truncated |

## Verification
Stream-end detection can fall in the same cycle as the completion of the payload, and in the same cycle as a malformed byte. The bench provokes the first case by raising in_last_i on the final payload byte, and on the final length byte of an empty payload. It requires done_o with no error. It provokes the second case by sending an illegal tag together with in_last_i, and requires the bad-tag code rather than the truncation code. A truncation in mid-payload is also checked: the bytes already sent must have gone out without out_last_o, and nothing may follow.

// File: rtl/bcp_pkg.sv
package bcp_pkg;
  typedef enum logic [2:0] {
    ST_PRE, ST_TAG, ST_LEN, ST_SKIP, ST_PAY, ST_DONE, ST_ERR
  } st_e;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_SIG      = 3'd1,
    ERR_TAG      = 3'd2,
    ERR_SIZE     = 3'd3,
    ERR_TRUNC    = 3'd4
  } err_e;

  localparam int unsigned SIG_BYTES   = 13;
  localparam logic [7:0]  TAG_FIRST   = 8'h61;
  localparam logic [7:0]  TAG_PAYLOAD = 8'h65;

  function automatic logic [7:0] sig_byte(input logic [3:0] idx);
    case (idx)
      4'd0:                   sig_byte = 8'h00;
      4'd1:                   sig_byte = 8'h09;
      4'd2, 4'd4, 4'd6, 4'd8: sig_byte = 8'h0F;
      4'd3, 4'd5, 4'd7, 4'd9: sig_byte = 8'hF0;
      4'd10, 4'd11:           sig_byte = 8'h00;
      4'd12:                  sig_byte = 8'h01;
      default:                sig_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/bcp_sig_match.sv
module bcp_sig_match
  import bcp_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       byte_i,
  output logic             match_o,
  output logic             final_o
);
  logic [3:0] idx4;
  assign idx4    = 4'(idx_i);
  assign match_o = (byte_i == sig_byte(idx4));
  assign final_o = (idx_i == IDX_W'(SIG_BYTES - 1));
endmodule

// File: rtl/bcp_len_acc.sv
module bcp_len_acc #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic [7:0]   byte_i,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] val_q;

  // big-endian: older bytes move up
  assign nxt_o = {val_q[W-9:0], byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      val_q <= '0;
    else if (clr_i)   val_q <= '0;
    else if (shift_i) val_q <= nxt_o;
  end
endmodule

// File: rtl/bcp_down_cnt.sv
module bcp_down_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         one_o
);
  logic [W-1:0] cnt_q;

  assign one_o = (cnt_q == W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - W'(1);
  end

  // R8
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> cnt_q != '0);
endmodule

// File: rtl/bitstream_container_parser.sv
module bitstream_container_parser
  import bcp_pkg::*;
#(
  parameter int unsigned LEN_W       = 32,
  parameter int unsigned SHORT_MAX   = 255,
  parameter int unsigned SHORT_BYTES = 2,
  parameter int unsigned LONG_BYTES  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       in_data_i,
  input  logic             in_valid_i,
  input  logic             in_last_i,
  output logic             in_ready_o,
  output logic [7:0]       out_data_o,
  output logic             out_valid_o,
  output logic             out_last_o,
  input  logic             out_ready_i,
  output logic [LEN_W-1:0] len_o,
  output logic             len_valid_o,
  output logic             done_o,
  output logic             err_o,
  output logic [2:0]       err_code_o
);
  localparam int unsigned IDX_W = $clog2(SIG_BYTES);

  st_e  st_q, st_d;
  err_e code_q, code_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic is_e_q, is_e_d;
  logic [LEN_W-1:0] len_q;
  logic len_vld_q;

  logic accept, sig_ok, sig_final, cnt_one;
  logic acc_clr, acc_shift, cnt_load, cnt_dec, len_set;
  logic [LEN_W-1:0] acc_nxt;
  logic [IDX_W-1:0] len_final_idx;

  bcp_sig_match #(.IDX_W(IDX_W)) u_sig (
    .idx_i(idx_q), .byte_i(in_data_i), .match_o(sig_ok), .final_o(sig_final)
  );

  bcp_len_acc #(.W(LEN_W)) u_acc (
    .clk_i, .rst_ni, .clr_i(acc_clr), .shift_i(acc_shift),
    .byte_i(in_data_i), .nxt_o(acc_nxt)
  );

  bcp_down_cnt #(.W(LEN_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(cnt_load), .load_val_i(acc_nxt),
    .dec_i(cnt_dec), .one_o(cnt_one)
  );

  // payload passes straight through; handshake is shared with the sink
  assign in_ready_o  = (st_q == ST_PAY) ? out_ready_i : 1'b1;
  assign out_valid_o = (st_q == ST_PAY) && in_valid_i;
  assign out_data_o  = in_data_i;
  assign out_last_o  = out_valid_o && cnt_one;
  assign accept      = in_valid_i && in_ready_o;

  assign len_final_idx = is_e_q ? IDX_W'(LONG_BYTES - 1) : IDX_W'(SHORT_BYTES - 1);

  always_comb begin
    st_d      = st_q;
    code_d    = code_q;
    idx_d     = idx_q;
    is_e_d    = is_e_q;
    acc_clr   = 1'b0;
    acc_shift = 1'b0;
    cnt_load  = 1'b0;
    cnt_dec   = 1'b0;
    len_set   = 1'b0;
    if (accept) begin
      unique case (st_q)
        ST_PRE: begin
          if (!sig_ok) begin
            st_d = ST_ERR; code_d = ERR_SIG;
          end else if (sig_final) begin
            st_d = ST_TAG;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
        ST_TAG: begin
          if (in_data_i < TAG_FIRST || in_data_i > TAG_PAYLOAD) begin
            st_d = ST_ERR; code_d = ERR_TAG;
          end else begin
            is_e_d  = (in_data_i == TAG_PAYLOAD);
            idx_d   = '0;
            acc_clr = 1'b1;
            st_d    = ST_LEN;
          end
        end
        ST_LEN: begin
          acc_shift = 1'b1;
          if (idx_q != len_final_idx) begin
            idx_d = idx_q + IDX_W'(1);
          end else if (is_e_q) begin
            len_set = 1'b1;
            if (acc_nxt == '0) st_d = ST_DONE;
            else begin
              cnt_load = 1'b1; st_d = ST_PAY;
            end
          end else if (acc_nxt > LEN_W'(SHORT_MAX)) begin
            st_d = ST_ERR; code_d = ERR_SIZE;
          end else if (acc_nxt == '0) begin
            st_d = ST_TAG;
          end else begin
            cnt_load = 1'b1; st_d = ST_SKIP;
          end
        end
        ST_SKIP: begin
          if (cnt_one) st_d = ST_TAG;
          else         cnt_dec = 1'b1;
        end
        ST_PAY: begin
          if (cnt_one) st_d = ST_DONE;
          else         cnt_dec = 1'b1;
        end
        default: ;
      endcase
      // end of stream that leaves the payload incomplete
      if (in_last_i && st_q != ST_DONE && st_q != ST_ERR &&
          st_d != ST_DONE && st_d != ST_ERR) begin
        st_d = ST_ERR; code_d = ERR_TRUNC;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_PRE;
      code_q    <= ERR_NONE;
      idx_q     <= '0;
      is_e_q    <= 1'b0;
      len_q     <= '0;
      len_vld_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      code_q <= code_d;
      idx_q  <= idx_d;
      is_e_q <= is_e_d;
      if (len_set) begin
        len_q     <= acc_nxt;
        len_vld_q <= 1'b1;
      end
    end
  end

  assign len_o       = len_q;
  assign len_valid_o = len_vld_q;
  assign done_o      = (st_q == ST_DONE);
  assign err_o       = (st_q == ST_ERR);
  assign err_code_o  = code_q;

  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o && $stable(err_code_o));
  // R10
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> in_ready_o && !out_valid_o);
  // R6
  len_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_valid_o |=> len_valid_o && $stable(len_o));
  // R6
  len_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> len_valid_o);
  // R8
  last_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_last_o) |=> done_o && !err_o);
  // R8
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && !out_valid_o);
endmodule

// File: tb/sim_bitstream_container_parser.sv
module sim_bitstream_container_parser;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [7:0]  in_data;
  logic        in_valid, in_last, in_ready;
  logic [7:0]  out_data;
  logic        out_valid, out_last, out_ready;
  logic [31:0] len;
  logic        len_valid, done, err;
  logic [2:0]  err_code;

  bitstream_container_parser u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_last_i(in_last), .in_ready_o(in_ready),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_last_o(out_last), .out_ready_i(out_ready),
    .len_o(len), .len_valid_o(len_valid), .done_o(done), .err_o(err), .err_code_o(err_code)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] got_d[$];
  logic       got_l[$];
  logic [7:0] sig[13] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F, 8'hF0,
                          8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};

  function automatic logic [7:0] pdat(int i);
    return 8'(i * 37 + 5);
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0; out_ready = 1'b1;
    got_d.delete(); got_l.delete();
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic push(logic [7:0] d, logic l = 1'b0, logic stall = 1'b0);
    in_data = d; in_last = l; in_valid = 1'b1;
    if (stall) begin
      out_ready = 1'b0;
      @(negedge clk);
      chk("R7", "in_ready under stall", in_ready, 0);
      chk("R7", "out_valid under stall", out_valid, 1);
      @(posedge clk); #1;
      out_ready = 1'b1;
    end
    forever begin
      @(negedge clk);
      if (in_ready) begin
        if (out_valid) begin
          got_d.push_back(out_data);
          got_l.push_back(out_last);
        end
        break;
      end
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic send_sig();
    for (int i = 0; i < 13; i++) push(sig[i]);
  endtask

  task automatic send_short(logic [7:0] tag, int n);
    push(tag); push(8'(n >> 8)); push(8'(n));
    for (int i = 0; i < n; i++) push(8'hA5);
  endtask

  task automatic send_e_hdr(int n, logic last_on_len = 1'b0);
    push(8'h65); push(8'(n >> 24)); push(8'(n >> 16)); push(8'(n >> 8)); push(8'(n), last_on_len);
  endtask

  task automatic check_payload(string req, int n);
    chk(req, "payload count", got_d.size(), n);
    for (int i = 0; i < n && i < got_d.size(); i++) begin
      chk(req, "payload byte", got_d[i], pdat(i));
      chk("R8", "last flag", got_l[i], (i == n - 1));
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "in_ready", in_ready, 1);
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "len_valid", len_valid, 0);
    chk("R1", "err", err, 0);
    chk("R1", "done", done, 0);
  endtask

  task automatic t_good();
    do_reset();
    send_sig();
    send_short(8'h61, 3);
    send_short(8'h64, 0);
    send_short(8'h63, 255);
    send_short(8'h62, 1);
    chk("R3", "no output from skipped sections", got_d.size(), 0);
    chk("R5", "255-byte short section accepted", err, 0);
    send_e_hdr(5);
    chk("R6", "len_valid before payload", len_valid, 1);
    chk("R6", "len value", len, 5);
    chk("R6", "no payload yet", got_d.size(), 0);
    for (int i = 0; i < 5; i++) push(pdat(i), i == 4, i == 2);
    check_payload("R7", 5);
    chk("R9", "last on final byte is not an error", err, 0);
    chk("R8", "done", done, 1);
    push(8'h11); push(8'h22); push(8'h33, 1'b1);
    chk("R8", "no output after done", got_d.size(), 5);
    chk("R8", "still done", done, 1);
    chk("R6", "len held", len, 5);
  endtask

  task automatic t_big_e();
    do_reset();
    send_sig();
    send_e_hdr(259);
    chk("R6", "big-endian length", len, 259);
    chk("R5", "long payload length allowed", err, 0);
    for (int i = 0; i < 259; i++) push(pdat(i), i == 258);
    check_payload("R7", 259);
    chk("R8", "done after long payload", done, 1);
  endtask

  task automatic t_zero_e();
    do_reset();
    send_sig();
    send_short(8'h62, 2);
    send_e_hdr(0, 1'b1);
    chk("R8", "zero payload done", done, 1);
    chk("R9", "zero payload with last no error", err, 0);
    chk("R6", "zero length valid", len_valid, 1);
    chk("R8", "zero payload no output", got_d.size(), 0);
  endtask

  task automatic t_bad_sig(int pos);
    do_reset();
    for (int i = 0; i < pos; i++) push(sig[i]);
    push(sig[pos] ^ 8'h10);
    chk("R2", $sformatf("signature mismatch at %0d", pos), err_code, 1);
    chk("R2", "err flag", err, 1);
    for (int i = 0; i < 13; i++) push(sig[i]);
    push(8'h65); push(8'h00); push(8'h00); push(8'h00); push(8'h02); push(8'h01);
    @(negedge clk);
    chk("R10", "ready while in error", in_ready, 1);
    chk("R10", "code held", err_code, 1);
    chk("R10", "no output in error", got_d.size(), 0);
    @(posedge clk); #1;
  endtask

  task automatic t_bad_tag();
    do_reset();
    send_sig();
    push(8'h66);
    chk("R4", "tag above range", err_code, 2);
    do_reset();
    send_sig();
    send_short(8'h61, 1);
    push(8'h60, 1'b1);
    chk("R4", "tag below range with last", err_code, 2);
  endtask

  task automatic t_oversize();
    do_reset();
    send_sig();
    push(8'h62); push(8'h01); push(8'h00);
    chk("R5", "short length 256", err_code, 3);
    push(8'h65);
    chk("R10", "code sticky", err_code, 3);
  endtask

  task automatic t_trunc();
    do_reset();
    push(sig[0]); push(sig[1]); push(sig[2], 1'b1);
    chk("R9", "end inside signature", err_code, 4);
    do_reset();
    send_sig();
    push(8'h61); push(8'h00); push(8'h02); push(8'hA5, 1'b1);
    chk("R9", "end inside skipped section", err_code, 4);
    do_reset();
    send_sig();
    send_e_hdr(4);
    push(pdat(0)); push(pdat(1), 1'b1);
    chk("R9", "end inside payload", err_code, 4);
    chk("R9", "bytes before end forwarded", got_d.size(), 2);
    if (got_d.size() == 2) chk("R8", "no last on cut payload", got_l[1], 0);
    push(pdat(2)); push(pdat(3));
    chk("R10", "no output after truncation", got_d.size(), 2);
    chk("R10", "done stays low", done, 0);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_good();
    t_big_e();
    t_zero_e();
    t_bad_sig(0);
    t_bad_sig(6);
    t_bad_sig(12);
    t_bad_tag();
    t_oversize();
    t_trunc();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule